// File: doc/BRIEF.md
# Two-Channel Calendar Alarm with Shared Interrupt/Clock Pin

This block watches the running clock and calendar of a real-time clock and compares it against two independent alarm settings. Each setting holds a target value for seconds, minutes, hours, date, month, year and weekday, plus one enable bit per field. A field whose enable is clear is treated as always matching. A partial mask therefore gives a repeating alarm: seconds alone fires once every minute, and weekday alone fires every Tuesday. Comparison happens only on the one-cycle second tick that the timekeeper supplies. One match therefore raises its status flag exactly once.

Each alarm channel is a two-state machine. ST_OFF is disarmed and ST_ARMED is armed. The transitions are ARM (ST_OFF to ST_ARMED on an arm pulse), DISARM (ST_ARMED to ST_OFF on a disarm pulse), FIRE_ONCE (ST_ARMED to ST_OFF on a match with repeat clear) and FIRE_REPEAT (ST_ARMED stays in ST_ARMED on a match with repeat set). A fired alarm latches a status flag that the host can poll. The flag stays set until the host pulses the clear for that channel.

One output pin is shared between two uses. A two-bit select picks either an active-low interrupt, driven from the flags whose interrupt enable is set, or one of three clock inputs. The three clocks are nominally 32768 Hz, 4096 Hz and 1 Hz, and they are generated outside this block.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset both flags read 0, both channels are disarmed, and with select 00 the pin reads 1.
- R2: An armed channel whose enabled fields all equal the live fields at a cycle with `sec_tick` high sets its flag at that clock edge. Without `sec_tick` no flag is set.
- R3: Field order in the packed vectors is seconds in bits [7:0], then minutes, hours, date, month and year, and finally weekday in bits [55:48]. Enable bit f belongs to field f. A field with its enable at 0 always counts as matching, so a mask of 0 matches every tick. A mismatch in any enabled field prevents the flag from being set.
- R4: A flag stays set until its `flag_clr` bit is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R5: With repeat set, a channel stays armed after firing and fires again on later matching ticks.
- R6: With repeat clear, a channel disarms itself at the edge where it fires. Later matching ticks then leave its flag clear.
- R7: A disarmed channel never sets its flag. An arm pulse arms it and a disarm pulse disarms it.
- R8: With select 00 the pin is 0 exactly when some flag is set and its `irq_en` bit is 1. A set flag whose `irq_en` is 0 leaves the pin at 1.
- R9: Select 01 routes `clk_32k_in`, 10 routes `clk_4k_in` and 11 routes `clk_1hz_in` to the pin. In these modes the flags have no effect on the pin.
- R10: The two channels are independent. A match on one channel leaves the other channel's flag and armed state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse when the live time has advanced |
| now_time | input | 56 | Live time fields, 8 bits each, seconds lowest |
| alm_val | input | 112 | Alarm targets, channel 0 in bits [55:0] |
| alm_field_en | input | 14 | Per-field enables, channel 0 in bits [6:0] |
| alm_repeat | input | 2 | Repeat mode per channel |
| alm_arm | input | 2 | Arm pulse per channel |
| alm_disarm | input | 2 | Disarm pulse per channel |
| irq_en | input | 2 | Interrupt enable per channel |
| flag_clr | input | 2 | Host clear pulse per flag |
| fo_sel | input | 2 | Pin mode: 00 interrupt, 01/10/11 clock |
| clk_32k_in | input | 1 | 32768 Hz source |
| clk_4k_in | input | 1 | 4096 Hz source |
| clk_1hz_in | input | 1 | 1 Hz source |
| alm_flag | output | 2 | Latched status flags |
| alm_armed | output | 2 | Armed state per channel |
| irq_freq_pin | output | 1 | Shared interrupt (active low) or clock output |

## Verification
A vector table sends alarm 0 through full, single-field and empty masks, and each vector pairs a matching live time with a near miss. A comparator that inverted the enable sense, or ignored a field, would raise the flag on the wrong vectors. Directed cases cover several situations. A clear that arrives together with a new match must not lose the event. A one-shot channel that stayed armed would set its flag again on the second matching tick. A masked flag must not pull the pin low. In the clock modes, a multiplexer that still looked at the flags would hold the pin at a fixed level. A disarmed channel must stay silent even when the live time equals its target.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;
    localparam int NUM_ALARMS = 2;

    typedef enum logic {
        ST_OFF   = 1'b0,
        ST_ARMED = 1'b1
    } alm_state_e;

    localparam logic [1:0] SEL_IRQ  = 2'b00;
    localparam logic [1:0] SEL_F32K = 2'b01;
    localparam logic [1:0] SEL_F4K  = 2'b10;
    localparam logic [1:0] SEL_F1   = 2'b11;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
    parameter int FW = 8,
    parameter int NF = 7
) (
    input  logic [NF*FW-1:0] live,
    input  logic [NF*FW-1:0] target,
    input  logic [NF-1:0]    field_en,
    output logic             hit
);
    logic [NF-1:0] field_ok;

    for (genvar f = 0; f < NF; f++) begin : g_field
        assign field_ok[f] = !field_en[f] ||
                             (live[f*FW +: FW] == target[f*FW +: FW]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic repeat_on,
    input  logic arm,
    input  logic disarm,
    input  logic clr,
    output logic flag,
    output logic armed
);
    alm_state_e state, state_nx;
    logic       fire;

    assign fire = tick && hit && (state == ST_ARMED) && !disarm;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (arm && !disarm) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (disarm)                 state_nx = ST_OFF;
                else if (fire && !repeat_on) state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flag <= 1'b0;
        else if (fire) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assign armed = (state == ST_ARMED);
endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import alarm_pkg::*;
#(
    parameter int NA = 2
) (
    input  logic [1:0]    sel,
    input  logic [NA-1:0] flags,
    input  logic [NA-1:0] irq_en,
    input  logic          f32k,
    input  logic          f4k,
    input  logic          f1,
    output logic          pin
);
    always_comb begin
        unique case (sel)
            SEL_IRQ:  pin = !(|(flags & irq_en));
            SEL_F32K: pin = f32k;
            SEL_F4K:  pin = f4k;
            SEL_F1:   pin = f1;
            default:  pin = 1'b1;
        endcase
    end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_pkg::*;
#(
    parameter int NA = NUM_ALARMS,
    parameter int NF = NUM_FIELDS,
    parameter int FW = FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [NF*FW-1:0] now_time,
    input  logic [NA*NF*FW-1:0] alm_val,
    input  logic [NA*NF-1:0] alm_field_en,
    input  logic [NA-1:0]    alm_repeat,
    input  logic [NA-1:0]    alm_arm,
    input  logic [NA-1:0]    alm_disarm,
    input  logic [NA-1:0]    irq_en,
    input  logic [NA-1:0]    flag_clr,
    input  logic [1:0]       fo_sel,
    input  logic             clk_32k_in,
    input  logic             clk_4k_in,
    input  logic             clk_1hz_in,
    output logic [NA-1:0]    alm_flag,
    output logic [NA-1:0]    alm_armed,
    output logic             irq_freq_pin
);
    localparam int SET_W = NF * FW;

    logic [NA-1:0] hit;

    for (genvar a = 0; a < NA; a++) begin : g_alm
        alarm_match #(.FW(FW), .NF(NF)) u_match (
            .live     (now_time),
            .target   (alm_val[a*SET_W +: SET_W]),
            .field_en (alm_field_en[a*NF +: NF]),
            .hit      (hit[a])
        );

        alarm_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (sec_tick),
            .hit       (hit[a]),
            .repeat_on (alm_repeat[a]),
            .arm       (alm_arm[a]),
            .disarm    (alm_disarm[a]),
            .clr       (flag_clr[a]),
            .flag      (alm_flag[a]),
            .armed     (alm_armed[a])
        );
    end

    pin_mux #(.NA(NA)) u_mux (
        .sel    (fo_sel),
        .flags  (alm_flag),
        .irq_en (irq_en),
        .f32k   (clk_32k_in),
        .f4k    (clk_4k_in),
        .f1     (clk_1hz_in),
        .pin    (irq_freq_pin)
    );
endmodule

// File: rtl/alarm_irq_checker.sv
module alarm_irq_checker #(
    parameter int NA = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic [NA-1:0] alm_repeat,
    input logic [NA-1:0] alm_disarm,
    input logic [NA-1:0] flag_clr,
    input logic [NA-1:0] irq_en,
    input logic [1:0]    fo_sel,
    input logic          clk_32k_in,
    input logic [NA-1:0] alm_flag,
    input logic [NA-1:0] alm_armed,
    input logic          irq_freq_pin
);
    for (genvar i = 0; i < NA; i++) begin : g_chk
        a_r2_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alm_flag[i]) |-> ($past(sec_tick) && $past(alm_armed[i])));

        a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(flag_clr[i]) && !$past(sec_tick)) |-> !alm_flag[i]);

        a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_flag[i] && !flag_clr[i]) |=> alm_flag[i]);

        a_r5_repeat_stays: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_armed[i] && alm_repeat[i] && !alm_disarm[i]) |=> alm_armed[i]);

        a_r6_oneshot_off: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(alm_armed[i]) && !$past(alm_disarm[i])) |->
            ($past(sec_tick) && !$past(alm_repeat[i]) && alm_flag[i]));
    end

    a_r8_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((fo_sel == 2'b00) && (|(alm_flag & irq_en))) |-> !irq_freq_pin);

    a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((fo_sel == 2'b00) && !(|(alm_flag & irq_en))) |-> irq_freq_pin);

    a_r9_fast_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_sel == 2'b01) |-> (irq_freq_pin == clk_32k_in));
endmodule

bind alarm_irq_unit alarm_irq_checker #(.NA(2)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .alm_repeat   (alm_repeat),
    .alm_disarm   (alm_disarm),
    .flag_clr     (flag_clr),
    .irq_en       (irq_en),
    .fo_sel       (fo_sel),
    .clk_32k_in   (clk_32k_in),
    .alm_flag     (alm_flag),
    .alm_armed    (alm_armed),
    .irq_freq_pin (irq_freq_pin)
);

// File: tb/alarm_irq_unit_tb.sv
module alarm_irq_unit_tb;
    localparam logic [55:0] T_ALM0 = 56'h02_24_03_21_05_15_30;
    localparam logic [55:0] T_DIFF = 56'h01_25_04_22_06_16_31;
    localparam int NV = 8;
    // {now_time[55:0], field enable[6:0], expected flag}
    localparam logic [63:0] VEC [NV] = '{
        {T_ALM0,                  7'h7F, 1'b1},
        {56'h02_24_03_21_05_15_31, 7'h7F, 1'b0},
        {56'h02_24_03_21_05_15_31, 7'h7E, 1'b1},
        {56'h02_25_04_22_06_16_31, 7'h40, 1'b1},
        {T_DIFF,                  7'h40, 1'b0},
        {56'h01_25_04_22_06_16_30, 7'h01, 1'b1},
        {T_DIFF,                  7'h00, 1'b1},
        {56'h02_25_03_21_05_15_30, 7'h7F, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sec_tick = 1'b0;
    logic [55:0]  now_time = '0;
    logic [111:0] alm_val = {T_DIFF, T_ALM0};
    logic [13:0]  alm_field_en = 14'h3FFF;
    logic [1:0]   alm_repeat = 2'b01;
    logic [1:0]   alm_arm = '0;
    logic [1:0]   alm_disarm = '0;
    logic [1:0]   irq_en = 2'b11;
    logic [1:0]   flag_clr = '0;
    logic [1:0]   fo_sel = 2'b00;
    logic         clk_32k_in = 1'b0;
    logic         clk_4k_in = 1'b0;
    logic         clk_1hz_in = 1'b0;
    logic [1:0]   alm_flag;
    logic [1:0]   alm_armed;
    logic         irq_freq_pin;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alarm_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_time(now_time),
        .alm_val(alm_val), .alm_field_en(alm_field_en), .alm_repeat(alm_repeat),
        .alm_arm(alm_arm), .alm_disarm(alm_disarm), .irq_en(irq_en),
        .flag_clr(flag_clr), .fo_sel(fo_sel), .clk_32k_in(clk_32k_in),
        .clk_4k_in(clk_4k_in), .clk_1hz_in(clk_1hz_in), .alm_flag(alm_flag),
        .alm_armed(alm_armed), .irq_freq_pin(irq_freq_pin)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags", alm_flag, 0);
        chk("R1 armed", alm_armed, 0);
        chk("R1 pin", irq_freq_pin, 1);
        rst_n = 1'b1;

        // arm alarm 0 only (repeat on)
        @(negedge clk) alm_arm = 2'b01;
        @(negedge clk) alm_arm = 2'b00;
        chk("R7 arm", alm_armed, 2'b01);

        for (int v = 0; v < NV; v++) begin
            now_time = VEC[v][63:8];
            alm_field_en[6:0] = VEC[v][7:1];
            tick_once();
            chk($sformatf("R3 vec%0d flag", v), alm_flag[0], VEC[v][0]);
            chk($sformatf("R8 vec%0d pin", v), irq_freq_pin, !VEC[v][0]);
            chk($sformatf("R7 vec%0d idle ch1", v), alm_flag[1], 0);
            clear(2'b11);
        end

        alm_field_en[6:0] = 7'h7F;
        now_time = T_ALM0;
        repeat (4) @(negedge clk);
        chk("R2 no tick", alm_flag[0], 0);

        tick_once();
        chk("R2 full match", alm_flag[0], 1);
        chk("R5 still armed", alm_armed[0], 1);
        repeat (5) @(negedge clk);
        chk("R4 hold", alm_flag[0], 1);
        clear(2'b01);
        chk("R4 cleared", alm_flag[0], 0);

        tick_once();
        chk("R5 fires again", alm_flag[0], 1);
        @(negedge clk) begin flag_clr = 2'b01; sec_tick = 1'b1; end
        @(negedge clk) begin flag_clr = 2'b00; sec_tick = 1'b0; end
        chk("R4 set beats clear", alm_flag[0], 1);

        irq_en = 2'b10;
        @(negedge clk);
        chk("R8 masked", irq_freq_pin, 1);
        irq_en = 2'b01;
        @(negedge clk);
        chk("R8 enabled", irq_freq_pin, 0);

        fo_sel = 2'b01; clk_32k_in = 1'b1; @(negedge clk);
        chk("R9 32k hi", irq_freq_pin, 1);
        clk_32k_in = 1'b0; @(negedge clk);
        chk("R9 32k lo", irq_freq_pin, 0);
        fo_sel = 2'b10; clk_4k_in = 1'b1; @(negedge clk);
        chk("R9 4k hi", irq_freq_pin, 1);
        fo_sel = 2'b11; clk_1hz_in = 1'b1; @(negedge clk);
        chk("R9 1hz hi", irq_freq_pin, 1);
        clk_1hz_in = 1'b0; @(negedge clk);
        chk("R9 1hz lo", irq_freq_pin, 0);
        fo_sel = 2'b00; irq_en = 2'b11;
        clear(2'b11);

        // one-shot alarm 1
        @(negedge clk) alm_arm = 2'b10;
        @(negedge clk) alm_arm = 2'b00;
        now_time = T_DIFF;
        tick_once();
        chk("R6 ch1 fired", alm_flag[1], 1);
        chk("R6 ch1 disarmed", alm_armed[1], 0);
        chk("R10 ch0 untouched", {alm_armed[0], alm_flag[0]}, 2'b10);
        clear(2'b10);
        tick_once();
        chk("R6 no refire", alm_flag[1], 0);

        @(negedge clk) alm_disarm = 2'b01;
        @(negedge clk) alm_disarm = 2'b00;
        chk("R7 disarm", alm_armed[0], 0);
        now_time = T_ALM0;
        tick_once();
        chk("R7 disarmed silent", alm_flag[0], 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule